// File: doc/BRIEF.md
# Multithreaded Warp Issue Scheduler

This block decides which resident warp drives the shared issue port of a SIMD lane array. Each warp's next instruction is represented only by a per-warp program counter. A warp is eligible when two things hold: the operand-ready input for that warp is high, and the warp is not waiting on a long-latency load. A scoreboard strobe marks a warp as waiting when it starts such a load. A completion strobe releases it when the data comes back.

When the issue port is free, the scheduler grants it to the eligible warp that has gone longest without issuing. It raises a one-cycle issue pulse that carries the warp number and its program counter, and every lane then runs that one instruction. The port stays occupied for a fixed dispatch window of several cycles while the instruction is broadcast. When the window ends, the next warp can issue in the very next cycle, even if it is a different warp, so switching warps adds no bubble. If no warp is eligible when the port is free, the scheduler flags the cycle as idle and tries again on the next cycle.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset every program counter and every age is 0, no load is pending and the port is free. With no warp ready, `issue_vld` and `disp_busy` are 0 and `sched_idle` is 1.
- R2: A warp is issued only in a cycle where its `opnd_rdy` bit is 1 and its pending-load bit is clear.
- R3: A block strobe (`ld_blk_vld`, `ld_blk_warp`) in cycle t makes that warp ineligible from cycle t+1. A completion strobe (`ld_done_vld`, `ld_done_warp`) in cycle t makes it eligible again from t+1. If both strobes name the same warp in the same cycle, the block wins.
- R4: Each warp's age counts the issues by other warps since its own last issue and saturates at 2^AGE_W-1. Issuing resets the issuing warp's own age to 0. The winner is the eligible warp with the largest age, and ties go to the lowest warp index.
- R5: An issue in cycle t occupies the port through cycle t+DISPATCH-1. During that window `disp_busy` is 1 and no further issue occurs.
- R6: In cycle t+DISPATCH, or in any later cycle in which the port is free, an issue occurs whenever at least one warp is eligible. No bubble is inserted, even when the winner is a different warp.
- R7: `issue_pc` equals the number of earlier issues of the same warp, modulo 2^PC_W.
- R8: `sched_idle` is 1 exactly in those cycles where the port is free and no warp is eligible. In an idle cycle nothing issues and `disp_busy` is 0.
- R9: `issue_vld` is a single-cycle pulse in the first cycle of the window. In that same cycle it reflects the current `opnd_rdy` and carries a valid `issue_warp` and `issue_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opnd_rdy | input | NW | Per-warp operand-ready flags for the next instruction |
| ld_blk_vld | input | 1 | Scoreboard strobe: a warp started a long-latency load |
| ld_blk_warp | input | ID_W | Warp that started the load |
| ld_done_vld | input | 1 | Completion strobe: load data returned |
| ld_done_warp | input | ID_W | Warp whose load completed |
| issue_vld | output | 1 | Pulse on the first cycle of a dispatch window |
| issue_warp | output | ID_W | Warp granted the port |
| issue_pc | output | PC_W | Program counter of the issued instruction |
| disp_busy | output | 1 | Issue port occupied by a dispatch window |
| sched_idle | output | 1 | Port free but no warp eligible |

## Verification
A corrupted age counter shows up at the ports the next time its warp competes with another eligible warp: the wrong warp wins the port in that same cycle. A lost or stuck pending bit shows up as an issue from a waiting warp, or as an idle cycle while a released warp is ready. Either appears in the first free slot after the strobe. A mistimed window counter shifts the next `issue_vld` by a cycle or more within four cycles. A wrong program counter appears on that warp's next issue.

// File: rtl/wis_pkg.sv
package wis_pkg;
  // Saturating increment used by the per-warp age counters.
  function automatic int unsigned sat_incr(int unsigned v, int unsigned top);
    return (v >= top) ? top : v + 1;
  endfunction

  // Wrapping increment of a program counter held in 'bits' bits.
  function automatic int unsigned wrap_incr(int unsigned v, int unsigned bits);
    return (v + 1) & ((32'd1 << bits) - 1);
  endfunction
endpackage

// File: rtl/wis_warp_state.sv
module wis_warp_state #(
  parameter int NW    = 16,
  parameter int PC_W  = 8,
  parameter int AGE_W = 4,
  localparam int ID_W = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_fire,
  input  logic [ID_W-1:0]   issue_id,
  input  logic              blk_vld,
  input  logic [ID_W-1:0]   blk_id,
  input  logic              done_vld,
  input  logic [ID_W-1:0]   done_id,
  output logic [NW*PC_W-1:0]  pc_flat,
  output logic [NW*AGE_W-1:0] age_flat,
  output logic [NW-1:0]       pend_vec
);
  localparam int unsigned AGE_TOP = (32'd1 << AGE_W) - 1;

  for (genvar g = 0; g < NW; g++) begin : g_warp
    logic [PC_W-1:0]  pc_q;
    logic [AGE_W-1:0] age_q;
    logic             pend_q;
    logic             won;

    assign won = issue_fire && (issue_id == ID_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pc_q   <= '0;
        age_q  <= '0;
        pend_q <= 1'b0;
      end else begin
        if (won)
          pc_q <= PC_W'(wis_pkg::wrap_incr(32'(pc_q), PC_W));
        if (issue_fire)
          age_q <= won ? '0 : AGE_W'(wis_pkg::sat_incr(32'(age_q), AGE_TOP));
        if (blk_vld && blk_id == ID_W'(g))
          pend_q <= 1'b1;
        else if (done_vld && done_id == ID_W'(g))
          pend_q <= 1'b0;
      end
    end

    assign pc_flat[g*PC_W +: PC_W]    = pc_q;
    assign age_flat[g*AGE_W +: AGE_W] = age_q;
    assign pend_vec[g]                = pend_q;
  end
endmodule

// File: rtl/wis_oldest_pick.sv
module wis_oldest_pick #(
  parameter int NW    = 16,
  parameter int AGE_W = 4,
  localparam int ID_W = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic [NW-1:0]       elig,
  input  logic [NW*AGE_W-1:0] age_flat,
  output logic                any,
  output logic [ID_W-1:0]     win
);
  logic [AGE_W-1:0] best;

  // Strictly-greater comparison keeps the lowest index on equal ages.
  always_comb begin
    any  = 1'b0;
    win  = '0;
    best = '0;
    for (int i = 0; i < NW; i++) begin
      if (elig[i] && (!any || age_flat[i*AGE_W +: AGE_W] > best)) begin
        any  = 1'b1;
        win  = ID_W'(i);
        best = age_flat[i*AGE_W +: AGE_W];
      end
    end
  end
endmodule

// File: rtl/wis_dispatch_timer.sv
module wis_dispatch_timer #(
  parameter int DISPATCH = 4,
  localparam int CNT_W = (DISPATCH > 2) ? $clog2(DISPATCH) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic open
);
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      left_q <= '0;
    else if (fire)
      left_q <= CNT_W'(DISPATCH - 1);
    else if (left_q != '0)
      left_q <= left_q - 1'b1;
  end

  assign open = (left_q == '0);
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NW       = 16,
  parameter int PC_W     = 8,
  parameter int AGE_W    = 4,
  parameter int DISPATCH = 4,
  localparam int ID_W    = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NW-1:0]   opnd_rdy,
  input  logic            ld_blk_vld,
  input  logic [ID_W-1:0] ld_blk_warp,
  input  logic            ld_done_vld,
  input  logic [ID_W-1:0] ld_done_warp,
  output logic            issue_vld,
  output logic [ID_W-1:0] issue_warp,
  output logic [PC_W-1:0] issue_pc,
  output logic            disp_busy,
  output logic            sched_idle
);
  // Named internal events, also observed by the bound checker.
  logic [NW*PC_W-1:0]  pc_flat;
  logic [NW*AGE_W-1:0] age_flat;
  logic [NW-1:0]       pend_vec;
  logic [NW-1:0]       elig_vec;
  logic                any_elig;
  logic [ID_W-1:0]     win_id;
  logic                slot_open;
  logic                fire;

  wis_warp_state #(.NW(NW), .PC_W(PC_W), .AGE_W(AGE_W)) u_state (
    .clk(clk), .rst_n(rst_n),
    .issue_fire(fire), .issue_id(win_id),
    .blk_vld(ld_blk_vld), .blk_id(ld_blk_warp),
    .done_vld(ld_done_vld), .done_id(ld_done_warp),
    .pc_flat(pc_flat), .age_flat(age_flat), .pend_vec(pend_vec)
  );

  assign elig_vec = opnd_rdy & ~pend_vec;

  wis_oldest_pick #(.NW(NW), .AGE_W(AGE_W)) u_pick (
    .elig(elig_vec), .age_flat(age_flat), .any(any_elig), .win(win_id)
  );

  wis_dispatch_timer #(.DISPATCH(DISPATCH)) u_timer (
    .clk(clk), .rst_n(rst_n), .fire(fire), .open(slot_open)
  );

  assign fire       = slot_open & any_elig;
  assign issue_vld  = fire;
  assign issue_warp = win_id;
  assign issue_pc   = pc_flat[win_id*PC_W +: PC_W];
  assign disp_busy  = fire | ~slot_open;
  assign sched_idle = slot_open & ~any_elig;
endmodule

// File: rtl/wis_checker.sv
module wis_checker #(
  parameter int NW    = 16,
  parameter int AGE_W = 4,
  localparam int ID_W = (NW > 1) ? $clog2(NW) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NW-1:0]     opnd_rdy,
  input logic [NW-1:0]     pend_vec,
  input logic [NW*AGE_W-1:0] age_flat,
  input logic              any_elig,
  input logic              ld_blk_vld,
  input logic [ID_W-1:0]   ld_blk_warp,
  input logic              issue_vld,
  input logic [ID_W-1:0]   issue_warp,
  input logic              disp_busy,
  input logic              sched_idle
);
  logic older_exists;
  logic [AGE_W-1:0] win_age;

  always_comb begin
    win_age      = age_flat[issue_warp*AGE_W +: AGE_W];
    older_exists = 1'b0;
    for (int i = 0; i < NW; i++) begin
      if (opnd_rdy[i] && !pend_vec[i] &&
          (age_flat[i*AGE_W +: AGE_W] > win_age ||
           (age_flat[i*AGE_W +: AGE_W] == win_age && i < int'(issue_warp))))
        older_exists = 1'b1;
    end
  end

  assert_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> (opnd_rdy[issue_warp] && !pend_vec[issue_warp]));

  assert_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_blk_vld |=> pend_vec[$past(ld_blk_warp)]);

  assert_oldest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> !older_exists);

  assert_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |=> (disp_busy && !issue_vld));

  assert_nobubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(disp_busy) || !disp_busy || issue_vld) && any_elig && !(disp_busy && !issue_vld)
      |-> issue_vld);

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sched_idle |-> (!issue_vld && !disp_busy && !any_elig));
endmodule

bind warp_issue_sched wis_checker #(.NW(NW), .AGE_W(AGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .opnd_rdy(opnd_rdy), .pend_vec(pend_vec),
  .age_flat(age_flat), .any_elig(any_elig), .ld_blk_vld(ld_blk_vld),
  .ld_blk_warp(ld_blk_warp), .issue_vld(issue_vld), .issue_warp(issue_warp),
  .disp_busy(disp_busy), .sched_idle(sched_idle)
);

// File: tb/warp_issue_sched_test.sv
module warp_issue_sched_test;
  localparam int NW = 16, PC_W = 8, AGE_W = 4, DISP = 4, ID_W = 4;
  localparam int AGE_TOP = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NW-1:0] opnd_rdy = '0;
  logic ld_blk_vld = 1'b0, ld_done_vld = 1'b0;
  logic [ID_W-1:0] ld_blk_warp = '0, ld_done_warp = '0;
  logic issue_vld, disp_busy, sched_idle;
  logic [ID_W-1:0] issue_warp;
  logic [PC_W-1:0] issue_pc;

  always #5 clk = ~clk;

  warp_issue_sched uut (
    .clk(clk), .rst_n(rst_n), .opnd_rdy(opnd_rdy),
    .ld_blk_vld(ld_blk_vld), .ld_blk_warp(ld_blk_warp),
    .ld_done_vld(ld_done_vld), .ld_done_warp(ld_done_warp),
    .issue_vld(issue_vld), .issue_warp(issue_warp), .issue_pc(issue_pc),
    .disp_busy(disp_busy), .sched_idle(sched_idle)
  );

  int checks = 0, errors = 0;
  bit done = 0, model_on = 0;
  int m_age[NW], m_pc[NW], m_cnt;
  bit m_pend[NW];

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int w = 0; w < NW; w++) begin m_age[w] = 0; m_pc[w] = 0; m_pend[w] = 0; end
    m_cnt = 0;
  endtask

  // Reference model: compare at the falling edge, then advance to the state
  // the design will hold after the next rising edge.
  always @(negedge clk) if (model_on && rst_n) begin
    int win; bit any; bit fire;
    any = 0; win = 0;
    for (int w = 0; w < NW; w++)
      if (opnd_rdy[w] && !m_pend[w] && (!any || m_age[w] > m_age[win])) begin
        any = 1; win = w;
      end
    fire = (m_cnt == 0) && any;
    chk(issue_vld == fire, "R2/R5/R6/R9 issue_vld", issue_vld, fire);
    chk(disp_busy == (fire || m_cnt != 0), "R5 disp_busy", disp_busy, fire || m_cnt != 0);
    chk(sched_idle == (m_cnt == 0 && !any), "R8 sched_idle", sched_idle, m_cnt == 0 && !any);
    if (fire && issue_vld) begin
      chk(int'(issue_warp) == win, "R4 issue_warp", issue_warp, win);
      chk(int'(issue_pc) == m_pc[win], "R7 issue_pc", issue_pc, m_pc[win]);
    end
    if (fire) begin
      for (int w = 0; w < NW; w++)
        m_age[w] = (w == win) ? 0 : ((m_age[w] >= AGE_TOP) ? AGE_TOP : m_age[w] + 1);
      m_pc[win] = (m_pc[win] + 1) % 256;
      m_cnt = DISP - 1;
    end else if (m_cnt > 0) m_cnt--;
    for (int w = 0; w < NW; w++) begin
      if (ld_blk_vld && int'(ld_blk_warp) == w) m_pend[w] = 1;
      else if (ld_done_vld && int'(ld_done_warp) == w) m_pend[w] = 0;
    end
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) step();
    @(negedge clk);
    // R1: reset state observed while held in reset, nothing ready.
    chk(issue_vld == 0, "R1 issue_vld in reset", issue_vld, 0);
    chk(sched_idle == 1, "R1 idle in reset", sched_idle, 1);
    step();
    rst_n = 1; model_on = 1;
    step();
    @(negedge clk);
    chk(sched_idle == 1 && disp_busy == 0, "R1 idle after reset", sched_idle, 1);
    step();
    // R6/R4: all ready, round robin from warp 0 with no bubbles.
    opnd_rdy = '1;
    @(negedge clk);
    chk(issue_vld == 1 && issue_warp == 0 && issue_pc == 0, "R1 first issue warp0 pc0",
        issue_warp, 0);
    repeat (80) step();
    // R3: block warps 2 and 5, same-cycle block and done on warp 7.
    ld_blk_vld = 1; ld_blk_warp = 2; step();
    ld_blk_warp = 5; step();
    ld_blk_warp = 7; ld_done_vld = 1; ld_done_warp = 7; step();
    ld_blk_vld = 0; ld_done_vld = 0;
    repeat (40) step();
    ld_done_vld = 1; ld_done_warp = 2; step();
    ld_done_warp = 5; step();
    ld_done_warp = 7; step();
    ld_done_vld = 0;
    repeat (20) step();
    // R8: nothing ready.
    opnd_rdy = '0;
    repeat (12) step();
    // Single warp ready: back-to-back issues of one warp every DISPATCH cycles.
    opnd_rdy = 16'h0400;
    repeat (24) step();
    // Random mix of readiness and scoreboard strobes.
    for (int c = 0; c < 4000; c++) begin
      opnd_rdy    = NW'($urandom) & NW'($urandom);
      ld_blk_vld  = ($urandom % 5) == 0;
      ld_blk_warp = ID_W'($urandom);
      ld_done_vld = ($urandom % 3) == 0;
      ld_done_warp = ID_W'($urandom);
      step();
    end
    ld_blk_vld = 0; ld_done_vld = 0; opnd_rdy = '0;
    repeat (5) step();
    finish_run();
  end
endmodule